// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a digital input clock by a programmable integer N and emits one short feedback pulse per N input cycles. The pulse is meant to drive the feedback side of a phase/frequency detector. The division uses the pulse-swallow method. A prescaler divides by either P+1 or P, where P is its lower modulus. A swallow counter sets how many prescaler periods run at P+1. A main counter sets how many prescaler periods make up one output period. The result is N = P·B + A, where A is the swallow value and B is the main value.

The whole design runs on the input clock. The prescaler produces a one-cycle enable that advances the two counters, so no derived clock is needed. Two lower moduli are fixed by parameters, 16 and 32 by default, and a one-bit input selects between them. The A value, the B value and the modulus select arrive on parallel ports. They are sampled only at the end of an output period, and only if they form a legal setting. An illegal setting is refused: the block raises an error flag and keeps dividing with the last legal setting.

Top module: `pulse_swallow_div`

## Requirements
- R1: The interval between successive rising edges of `fb_pulse_o` equals P·B + A input cycles. P is 16 when `pair_sel_i` is 0 and 32 when it is 1, taken from the settings captured at the start of that interval.
- R2: `fb_pulse_o` is high for exactly one input cycle per output period and never two cycles in a row.
- R3: With A = 0 every prescaler period uses modulus P, so the ratio is exactly P·B.
- R4: With A = B every prescaler period uses P+1, so the ratio is (P+1)·B. The next period again starts at P+1.
- R5: The largest swallow value, A = 31, is accepted whenever B ≥ 31.
- R6: The largest main value, B = 8191, gives the ratio P·8191 + A.
- R7: Ratios below the continuous minimum P·(P−1) are produced exactly whenever B ≥ A and B ≥ 3. Examples are 51 and 98.
- R8: Input values are captured only on the clock edge that raises `fb_pulse_o`. Values applied and then withdrawn inside a period have no effect on any interval.
- R9: A setting with B < A or B < 3, presented at a period boundary, is refused. From that edge `cfg_err_o` reads 1 and the previous legal setting keeps governing the period. The next legal capture returns `cfg_err_o` to 0.
- R10: While `rst_i` is high both outputs are 0. The first clock after reset loads the inputs. The first pulse is seen N+1 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| pair_sel_i | input | 1 | Modulus select: 0 gives P=16 (17), 1 gives P=32 (33) |
| swal_i | input | 5 | Swallow value A, 0 to 31 |
| main_i | input | 13 | Main value B, 3 to 8191 |
| fb_pulse_o | output | 1 | One-cycle feedback pulse per N input cycles |
| cfg_err_o | output | 1 | Result of the latest capture: 1 when it was refused |

## Verification
Two events can share one prescaler tick: the swallow count reaching zero and the main count finishing the period. They coincide when A = B, since the final swallowed prescaler period is also the last period of the output cycle. At that tick the modulus for the next prescaler period must come from the freshly captured setting, not from the exhausted swallow count. The bench provokes this with A = B for both moduli, and also with B = 31, A = 31. It judges the result by measuring every interval between pulses against (P+1)·B. Any error in the reload order shows up as an interval that is off by one prescaler period or by a few input cycles.

// File: rtl/pulse_swallow_div_pkg.sv
package pulse_swallow_div_pkg;

  // Width of the swallow (A) value.
  localparam int unsigned SWAL_W = 5;
  // Width of the main (B) value.
  localparam int unsigned MAIN_W = 13;

  // One divider setting as applied to the datapath.
  typedef struct packed {
    logic              hi_pair;
    logic [SWAL_W-1:0] swal;
    logic [MAIN_W-1:0] main;
  } div_cfg_t;

endpackage

// File: rtl/psd_cfg_hold.sv
module psd_cfg_hold
  import pulse_swallow_div_pkg::*;
#(
  parameter int unsigned MAIN_MIN = 3
) (
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     capture_i,
  input  div_cfg_t req_i,
  output div_cfg_t act_o,
  output logic     ok_o,
  output logic     err_o
);

  localparam logic [MAIN_W-1:0] MAIN_FLOOR = MAIN_W'(MAIN_MIN);
  localparam int unsigned PAD_W = MAIN_W - SWAL_W;

  div_cfg_t act_q;
  logic     err_q;
  logic     req_ok;

  // A legal request keeps the main count at or above the swallow count
  // and at or above the floor needed for the reload to settle.
  always_comb begin
    req_ok = (req_i.main >= {{PAD_W{1'b0}}, req_i.swal}) &&
             (req_i.main >= MAIN_FLOOR);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q.hi_pair <= 1'b0;
      act_q.swal    <= '0;
      act_q.main    <= MAIN_FLOOR;
      err_q         <= 1'b0;
    end else if (capture_i) begin
      if (req_ok) begin
        act_q <= req_i;
        err_q <= 1'b0;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign act_o = act_q;
  assign ok_o  = req_ok;
  assign err_o = err_q;

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned P_LO_0 = 16,
  parameter int unsigned P_LO_1 = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic load_i,
  input  logic pair_i,
  input  logic hi_i,
  output logic tick_o
);

  localparam int unsigned P_BIG = (P_LO_0 > P_LO_1) ? P_LO_0 : P_LO_1;
  localparam int unsigned CNT_W = $clog2(P_BIG + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pair_q;
  logic             pair_use;
  logic [CNT_W-1:0] p_lo;
  logic [CNT_W-1:0] reload_val;
  logic             tick;

  // On a restart the new pair applies at once; otherwise the stored one.
  always_comb begin
    pair_use   = load_i ? pair_i : pair_q;
    p_lo       = pair_use ? CNT_W'(P_LO_1) : CNT_W'(P_LO_0);
    // Counting from reload_val down to zero takes reload_val+1 cycles.
    reload_val = hi_i ? p_lo : (p_lo - CNT_W'(1));
    tick       = run_i && (cnt_q == '0);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      pair_q <= 1'b0;
    end else begin
      if (load_i || tick) begin
        cnt_q <= reload_val;
      end else if (run_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (load_i) begin
        pair_q <= pair_i;
      end
    end
  end

  assign tick_o = tick;

endmodule

// File: rtl/psd_swallow_ctl.sv
module psd_swallow_ctl
  import pulse_swallow_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              tick_i,
  input  logic [SWAL_W-1:0] swal_ld_i,
  input  logic [MAIN_W-1:0] main_ld_i,
  output logic              wrap_o,
  output logic              hi_o,
  output logic [SWAL_W-1:0] swal_rem_o,
  output logic [MAIN_W-1:0] main_rem_o
);

  logic [SWAL_W-1:0] swal_q;
  logic [MAIN_W-1:0] main_q;

  // The period ends on the tick that consumes the last main count.
  // The modulus of the next prescaler period is chosen here: on a reload
  // it follows the incoming swallow value, otherwise the swallow count
  // still remaining after this tick.
  always_comb begin
    wrap_o = tick_i && (main_q == MAIN_W'(1));
    hi_o   = load_i ? (swal_ld_i != '0) : (swal_q > SWAL_W'(1));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      swal_q <= '0;
      main_q <= '0;
    end else if (load_i) begin
      swal_q <= swal_ld_i;
      main_q <= main_ld_i;
    end else if (tick_i) begin
      main_q <= main_q - MAIN_W'(1);
      if (swal_q != '0) begin
        swal_q <= swal_q - SWAL_W'(1);
      end
    end
  end

  assign swal_rem_o = swal_q;
  assign main_rem_o = main_q;

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import pulse_swallow_div_pkg::*;
#(
  parameter int unsigned P_LO_0   = 16,
  parameter int unsigned P_LO_1   = 32,
  parameter int unsigned MAIN_MIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              pair_sel_i,
  input  logic [SWAL_W-1:0] swal_i,
  input  logic [MAIN_W-1:0] main_i,
  output logic              fb_pulse_o,
  output logic              cfg_err_o
);

  div_cfg_t          req_cfg;
  div_cfg_t          act_cfg;
  div_cfg_t          nxt_cfg;
  logic              req_ok;
  logic              prime_q;
  logic              load;
  logic              tick;
  logic              wrap;
  logic              hi;
  logic              pulse_q;
  logic [SWAL_W-1:0] swal_rem;
  logic [MAIN_W-1:0] main_rem;

  always_comb begin
    req_cfg.hi_pair = pair_sel_i;
    req_cfg.swal    = swal_i;
    req_cfg.main    = main_i;
    // The setting that governs the period starting at this edge.
    nxt_cfg         = req_ok ? req_cfg : act_cfg;
    load            = wrap || prime_q;
  end

  // One idle cycle after reset in which everything is loaded.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prime_q <= 1'b1;
    end else begin
      prime_q <= 1'b0;
    end
  end

  psd_cfg_hold #(
    .MAIN_MIN (MAIN_MIN)
  ) u_hold (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .capture_i (load),
    .req_i     (req_cfg),
    .act_o     (act_cfg),
    .ok_o      (req_ok),
    .err_o     (cfg_err_o)
  );

  psd_prescaler #(
    .P_LO_0 (P_LO_0),
    .P_LO_1 (P_LO_1)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (!prime_q),
    .load_i (load),
    .pair_i (nxt_cfg.hi_pair),
    .hi_i   (hi),
    .tick_o (tick)
  );

  psd_swallow_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (load),
    .tick_i     (tick),
    .swal_ld_i  (nxt_cfg.swal),
    .main_ld_i  (nxt_cfg.main),
    .wrap_o     (wrap),
    .hi_o       (hi),
    .swal_rem_o (swal_rem),
    .main_rem_o (main_rem)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
    end
  end

  assign fb_pulse_o = pulse_q;

endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk
  import pulse_swallow_div_pkg::*;
#(
  parameter int unsigned MAIN_MIN = 3
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              fb_pulse_o,
  input logic              cfg_err_o,
  input logic              prime_q,
  input div_cfg_t          act_cfg,
  input logic [SWAL_W-1:0] swal_rem,
  input logic [MAIN_W-1:0] main_rem
);

  // R2
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fb_pulse_o |=> !fb_pulse_o);

  // R9
  act_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_cfg.main >= MAIN_W'(act_cfg.swal)) && (act_cfg.main >= MAIN_W'(MAIN_MIN)));

  // R8
  cfg_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(act_cfg) |-> (fb_pulse_o || $past(prime_q)));

  // R9
  err_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(cfg_err_o) |-> (fb_pulse_o || $past(prime_q)));

  // R4
  rem_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    MAIN_W'(swal_rem) <= main_rem);

  // R1
  reload_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fb_pulse_o |-> ((main_rem == act_cfg.main) && (swal_rem == act_cfg.swal)));

endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(
  .MAIN_MIN (MAIN_MIN)
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .fb_pulse_o (fb_pulse_o),
  .cfg_err_o  (cfg_err_o),
  .prime_q    (prime_q),
  .act_cfg    (act_cfg),
  .swal_rem   (swal_rem),
  .main_rem   (main_rem)
);

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;

  localparam int P0    = 16;
  localparam int P1    = 32;
  localparam int WATCH = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_r = 1'b0;
  logic [4:0]  swal_r = 5'd0;
  logic [12:0] main_r = 13'd3;
  logic        pulse_w;
  logic        err_w;

  always #2 clk = ~clk;

  pulse_swallow_div #(
    .P_LO_0 (P0),
    .P_LO_1 (P1)
  ) u_pulse_swallow_div (
    .clk_i      (clk),
    .rst_i      (rst),
    .pair_sel_i (sel_r),
    .swal_i     (swal_r),
    .main_i     (main_r),
    .fb_pulse_o (pulse_w),
    .cfg_err_o  (err_w)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  int    since = 0;
  int    cyc = 0;
  bit    seen_first = 1'b0;
  bit    prev_pulse = 1'b0;
  bit    done = 1'b0;
  int    lv_sel = 0;
  int    lv_a = 0;
  int    lv_b = 3;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  // Monitor: measures every interval between pulses and scores it.
  always @(negedge clk) begin : monitor
    string t;
    int    e;
    cyc++;
    if (cyc >= WATCH && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCH);
      summary();
      $finish;
    end
    if (!rst) begin
      since++;
      if (pulse_w) begin
        check("R2 pulse width", int'(prev_pulse), 0);
        if (!seen_first) begin
          // R10: reset values 0/3/sel0 are loaded, so N = 48
          check("R10 first pulse delay", since, 3 * P0 + 1);
          seen_first = 1'b1;
        end else if (exp_q.size() == 0) begin
          check("R2 unexpected pulse", since, 0);
        end else begin
          t = tag_q.pop_front();
          e = exp_q.pop_front();
          check(t, since, e);
        end
        since = 0;
      end
      prev_pulse = pulse_w;
    end
  end

  // Driver: applies a setting, waits for its capture edge and queues
  // the intervals it must produce, computed from the bench's own model.
  task automatic run_cfg(input string tag, input bit s, input int av, input int bv,
                         input int reps, input bit decoy = 1'b0, input bit ds = 1'b0,
                         input int da = 0, input int db = 0);
    bit ok;
    int n;
    @(negedge clk);
    #1;
    if (decoy) begin
      sel_r  = ds;
      swal_r = 5'(da);
      main_r = 13'(db);
      repeat (20) @(negedge clk);
      #1;
    end
    sel_r  = s;
    swal_r = 5'(av);
    main_r = 13'(bv);
    ok = (bv >= av) && (bv >= 3);
    if (ok) begin
      lv_sel = int'(s);
      lv_a   = av;
      lv_b   = bv;
    end
    n = ((lv_sel != 0) ? P1 : P0) * lv_b + lv_a;
    @(negedge clk iff pulse_w);
    check({tag, " R9 error flag"}, int'(err_w), ok ? 0 : 1);
    repeat (reps) begin
      exp_q.push_back(n);
      tag_q.push_back(tag);
    end
    repeat (reps - 1) @(negedge clk iff pulse_w);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      check("R10 reset pulse low", int'(pulse_w), 0);
      check("R10 reset error low", int'(err_w), 0);
    end
    #1 rst = 1'b0;

    run_cfg("R1 sel0 A5 B10", 1'b0, 5, 10, 2);
    run_cfg("R1 sel1 A7 B12", 1'b1, 7, 12, 2);
    run_cfg("R3 sel0 A0 B20", 1'b0, 0, 20, 2);
    run_cfg("R3 sel1 A0 B4", 1'b1, 0, 4, 1);
    run_cfg("R4 sel0 A9 B9", 1'b0, 9, 9, 2);
    run_cfg("R4 R5 sel1 A31 B31", 1'b1, 31, 31, 1);
    run_cfg("R5 sel0 A31 B40", 1'b0, 31, 40, 1);
    run_cfg("R7 sel0 A3 B3", 1'b0, 3, 3, 2);
    run_cfg("R7 sel1 A2 B3", 1'b1, 2, 3, 1);
    run_cfg("R9 hold on B<A", 1'b0, 10, 5, 2);
    run_cfg("R9 hold on B<3", 1'b0, 0, 2, 1);
    run_cfg("R9 legal recovery", 1'b0, 1, 3, 1);
    run_cfg("R8 decoy withdrawn", 1'b0, 4, 7, 2, 1'b1, 1'b1, 5, 9);
    run_cfg("R6 sel0 A31 B8191", 1'b0, 31, 8191, 1);

    @(negedge clk iff pulse_w);
    #1;
    check("R2 all intervals seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule